// File: doc/BRIEF.md
# Compare and Set-Flag Unit

This block executes the compare instructions of a 32-bit integer pipeline. Each accepted compare checks operand A against either operand B or a 16-bit immediate from the instruction word. The result is written into a single registered condition flag. Later conditional branches read that flag. A compare never produces a general-register result. The flag is its only architectural effect.

Instructions arrive on a valid/ready input stream together with both operand values. The unit can finish any compare in one cycle, so it never applies back-pressure. The ready output is high at all times, and every cycle in which valid is high is one accepted transfer. A valid instruction that is not a compare is accepted and leaves the flag untouched. A malformed compare is also accepted. It leaves the flag untouched and raises an illegal-instruction strobe for one cycle.

Top module: `cmpf_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the edge clears `flag` to 0 and `illegal` to 0.
- R2: A register compare has insn[31:30]=3, insn[29:26]=9 and insn[10:0]=0, and it compares `op_a` against `op_b`.
- R3: An immediate compare has insn[31:30]=2 and insn[29:26]=14, and it compares `op_a` against the 16-bit immediate in insn[15:0].
- R4: A condition code in insn[25:21] of 0 sets the flag when the operands are equal. A code of 1 sets it when they differ.
- R5: Condition codes 2, 3, 4 and 5 select unsigned greater-than, greater-or-equal, less-than and less-or-equal.
- R6: Condition codes 6, 7, 8 and 9 select the same four relations in two's-complement signed arithmetic.
- R7: For condition codes 0, 1 and 6 to 9, the immediate is sign-extended to 32 bits. For codes 2 to 5 it is zero-extended.
- R8: The flag takes the new result on the rising edge that samples a valid, well-formed compare. It holds its value when valid is low or the instruction is not a compare.
- R9: A compare whose condition code is above 9 leaves the flag unchanged. On the following edge, `illegal` goes high for exactly one cycle.
- R10: A register compare with any of insn[10:0] set is treated as illegal in the same way as R9.
- R11: `in_ready` is high in every cycle, including during reset, so no instruction is ever stalled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction and operands are present |
| in_ready | output | 1 | Unit accepts input (always high) |
| insn | input | 32 | Instruction word |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand (register compares) |
| flag | output | 1 | Registered condition flag |
| illegal | output | 1 | One-cycle strobe for a malformed compare |

## Verification
Operand pairs are chosen so that signed and unsigned orderings disagree, for example 0x80000000 against 0x7fffffff. This exposes any swap between the unsigned code group and the signed one. Immediates with bit 15 set tell sign extension apart from zero extension. Equal operands separate the strict relations from the inclusive ones. A long run of random mixes covers several cases. It includes compares, non-compare instructions, idle cycles, out-of-range codes and dirty low bits. Together these show that the flag moves only on legal compares and that the illegal strobe lasts one cycle.

// File: rtl/cmpf_pkg.sv
package cmpf_pkg;

  // Instruction field positions; the decoder depends on these.
  localparam int CLS_HI  = 31;
  localparam int CLS_LO  = 30;
  localparam int SUB_HI  = 29;
  localparam int SUB_LO  = 26;
  localparam int CC_HI   = 25;
  localparam int CC_LO   = 21;
  localparam int PAD_HI  = 10;

  localparam logic [1:0] CLS_REG = 2'd3;
  localparam logic [3:0] SUB_REG = 4'd9;
  localparam logic [1:0] CLS_IMM = 2'd2;
  localparam logic [3:0] SUB_IMM = 4'd14;

  localparam int CC_W = CC_HI - CC_LO + 1;

  // Condition codes
  localparam logic [CC_W-1:0] CC_EQ    = 5'd0;
  localparam logic [CC_W-1:0] CC_NE    = 5'd1;
  localparam logic [CC_W-1:0] CC_UBASE = 5'd2;
  localparam logic [CC_W-1:0] CC_SBASE = 5'd6;
  localparam logic [CC_W-1:0] CC_LAST  = 5'd9;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_REG  = 2'd1,
    KIND_IMM  = 2'd2
  } cmp_kind_e;

  // Ordering relation after signedness is stripped from the code
  typedef enum logic [1:0] {
    REL_GT = 2'd0,
    REL_GE = 2'd1,
    REL_LT = 2'd2,
    REL_LE = 2'd3
  } cmp_rel_e;

endpackage

// File: rtl/cmpf_decode.sv
module cmpf_decode
  import cmpf_pkg::*;
#(
  parameter int INSN_W = 32,
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              valid_i,
  input  logic [INSN_W-1:0] insn_i,
  input  logic [DATA_W-1:0] op_b_i,
  output cmp_kind_e         kind_o,
  output logic [CC_W-1:0]   cond_o,
  output logic [DATA_W-1:0] rhs_o,
  output logic              upd_o,
  output logic              bad_o
);

  localparam int EXT_W = DATA_W - IMM_W;

  logic [IMM_W-1:0]  imm;
  logic              imm_signed;
  logic [DATA_W-1:0] imm_ext;
  logic              code_ok;
  logic              pad_ok;

  always_comb begin
    if (insn_i[CLS_HI:CLS_LO] == CLS_REG && insn_i[SUB_HI:SUB_LO] == SUB_REG)
      kind_o = KIND_REG;
    else if (insn_i[CLS_HI:CLS_LO] == CLS_IMM && insn_i[SUB_HI:SUB_LO] == SUB_IMM)
      kind_o = KIND_IMM;
    else
      kind_o = KIND_NONE;
  end

  assign cond_o  = insn_i[CC_HI:CC_LO];
  assign imm     = insn_i[IMM_W-1:0];
  assign code_ok = (cond_o <= CC_LAST);
  assign pad_ok  = (insn_i[PAD_HI:0] == '0);

  // Only the unsigned ordering codes zero-extend the immediate.
  assign imm_signed = !(cond_o >= CC_UBASE && cond_o < CC_SBASE);
  assign imm_ext    = {{EXT_W{imm_signed & imm[IMM_W-1]}}, imm};

  assign rhs_o = (kind_o == KIND_IMM) ? imm_ext : op_b_i;

  always_comb begin
    upd_o = 1'b0;
    bad_o = 1'b0;
    if (valid_i) begin
      unique case (kind_o)
        KIND_REG: begin
          upd_o = code_ok && pad_ok;
          bad_o = !(code_ok && pad_ok);
        end
        KIND_IMM: begin
          upd_o = code_ok;
          bad_o = !code_ok;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/cmpf_compare.sv
module cmpf_compare
  import cmpf_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter bit SHARED_SUB = 1'b1
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [CC_W-1:0]   cond_i,
  output logic              result_o
);

  logic     is_signed;
  logic     lt;
  logic     eq;
  cmp_rel_e rel;

  assign is_signed = (cond_i >= CC_SBASE);
  assign eq        = (a_i == b_i);

  always_comb begin
    logic [CC_W-1:0] off;
    off = is_signed ? (cond_i - CC_SBASE) : (cond_i - CC_UBASE);
    rel = cmp_rel_e'(off[1:0]);
  end

  generate
    if (SHARED_SUB) begin : g_shared
      // One subtractor serves both signednesses.
      // Flipping the sign bits turns a signed order into an unsigned one.
      logic [DATA_W-1:0] xa;
      logic [DATA_W-1:0] xb;
      logic [DATA_W:0]   diff;
      assign xa   = {a_i[DATA_W-1] ^ is_signed, a_i[DATA_W-2:0]};
      assign xb   = {b_i[DATA_W-1] ^ is_signed, b_i[DATA_W-2:0]};
      assign diff = {1'b0, xa} - {1'b0, xb};
      assign lt   = diff[DATA_W];
    end else begin : g_split
      logic lt_u;
      logic lt_s;
      assign lt_u = (a_i < b_i);
      assign lt_s = ($signed(a_i) < $signed(b_i));
      assign lt   = is_signed ? lt_s : lt_u;
    end
  endgenerate

  always_comb begin
    if (cond_i == CC_EQ)
      result_o = eq;
    else if (cond_i == CC_NE)
      result_o = !eq;
    else begin
      unique case (rel)
        REL_GT:  result_o = !lt && !eq;
        REL_GE:  result_o = !lt;
        REL_LT:  result_o = lt;
        default: result_o = lt || eq;
      endcase
    end
  end

endmodule

// File: rtl/cmpf_state.sv
module cmpf_state (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_i,
  input  logic bad_i,
  input  logic result_i,
  output logic flag_o,
  output logic illegal_o
);

  logic flag_q;
  logic illegal_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q    <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      if (upd_i)
        flag_q <= result_i;
      illegal_q <= bad_i;
    end
  end

  assign flag_o    = flag_q;
  assign illegal_o = illegal_q;

  // R1: reset clears both registers
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (!flag_o && !illegal_o));

  // R8: no update request, no flag change
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> $stable(flag_o));

  // R9: a request cannot be both an update and an illegal compare
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({upd_i, bad_i}));

  // R9: an illegal compare raises the strobe and keeps the flag
  a_r9_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    bad_i |=> (illegal_o && $stable(flag_o)));

endmodule

// File: rtl/cmpf_unit.sv
module cmpf_unit
  import cmpf_pkg::*;
#(
  parameter int INSN_W     = 32,
  parameter int DATA_W     = 32,
  parameter int IMM_W      = 16,
  parameter bit SHARED_SUB = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [INSN_W-1:0] insn,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic              flag,
  output logic              illegal
);

  cmp_kind_e         kind;
  logic [CC_W-1:0]   cond;
  logic [DATA_W-1:0] rhs;
  logic              upd;
  logic              bad;
  logic              result;

  assign in_ready = 1'b1;

  cmpf_decode #(.INSN_W(INSN_W), .DATA_W(DATA_W), .IMM_W(IMM_W)) u_dec (
    .valid_i (in_valid),
    .insn_i  (insn),
    .op_b_i  (op_b),
    .kind_o  (kind),
    .cond_o  (cond),
    .rhs_o   (rhs),
    .upd_o   (upd),
    .bad_o   (bad)
  );

  cmpf_compare #(.DATA_W(DATA_W), .SHARED_SUB(SHARED_SUB)) u_cmp (
    .a_i      (op_a),
    .b_i      (rhs),
    .cond_i   (cond),
    .result_o (result)
  );

  cmpf_state u_st (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_i     (upd),
    .bad_i     (bad),
    .result_i  (result),
    .flag_o    (flag),
    .illegal_o (illegal)
  );

  // R4: register equality compare lands in the flag
  a_r4_reg_eq: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && insn[31:26] == {CLS_REG, SUB_REG} && insn[25:21] == CC_EQ
     && insn[10:0] == '0)
    |=> flag == ($past(op_a) == $past(op_b)));

  // R5: unsigned less-than register compare
  a_r5_reg_ltu: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && insn[31:26] == {CLS_REG, SUB_REG} && insn[25:21] == 5'd4
     && insn[10:0] == '0)
    |=> flag == ($past(op_a) < $past(op_b)));

  // R11: never stalls
  a_r11_ready: assert property (@(posedge clk) in_ready);

endmodule

// File: tb/cmpf_unit_test.sv
module cmpf_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] insn = '0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        flag;
  logic        illegal;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  bit exp_flag = 1'b0;
  bit exp_ill  = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  cmpf_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .insn(insn), .op_a(op_a), .op_b(op_b), .flag(flag), .illegal(illegal)
  );

  function automatic logic [31:0] mk_reg(int code, logic [10:0] pad);
    return {2'd3, 4'd9, code[4:0], 5'd0, 5'd0, pad};
  endfunction

  function automatic logic [31:0] mk_imm(int code, logic [15:0] imm);
    return {2'd2, 4'd14, code[4:0], 5'd0, imm};
  endfunction

  // Behavioural reference: returns 1 in upd when the flag should change.
  task automatic model(input bit v, input logic [31:0] w, input logic [31:0] a,
                       input logic [31:0] b, output bit upd, output bit bad,
                       output bit res);
    longint sa, sb, ua, ub;
    int code;
    bit is_reg, is_imm;
    upd = 0; bad = 0; res = 0;
    is_reg = (w[31:30] == 2'd3) && (w[29:26] == 4'd9);
    is_imm = (w[31:30] == 2'd2) && (w[29:26] == 4'd14);
    code = int'(w[25:21]);
    if (!v || (!is_reg && !is_imm)) return;
    if (code > 9 || (is_reg && w[10:0] != 0)) begin bad = 1; return; end
    upd = 1;
    if (is_imm) begin
      if (code >= 2 && code <= 5) b = {16'h0, w[15:0]};
      else b = {{16{w[15]}}, w[15:0]};
    end
    ua = longint'(a); ub = longint'(b);
    sa = longint'($signed(a)); sb = longint'($signed(b));
    if (code >= 6) begin ua = sa; ub = sb; end
    case (code)
      0: res = (a == b);
      1: res = (a != b);
      2, 6: res = (ua > ub);
      3, 7: res = (ua >= ub);
      4, 8: res = (ua < ub);
      default: res = (ua <= ub);
    endcase
  endtask

  task automatic check(input string tag);
    n_checks++;
    if (flag !== exp_flag) begin
      n_fail++;
      $display("FAIL %s flag actual=%b expected=%b", tag, flag, exp_flag);
    end
    n_checks++;
    if (illegal !== exp_ill) begin
      n_fail++;
      $display("FAIL %s illegal actual=%b expected=%b", tag, illegal, exp_ill);
    end
    n_checks++;
    if (in_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R11 in_ready actual=%b expected=1", in_ready);
    end
  endtask

  // Drive at negedge, advance one edge, update model, check at next negedge.
  task automatic step(input bit v, input logic [31:0] w, input logic [31:0] a,
                      input logic [31:0] b, input string tag);
    bit u, bd, r;
    in_valid = v; insn = w; op_a = a; op_b = b;
    model(v, w, a, b, u, bd, r);
    @(posedge clk);
    if (!rst_n) begin exp_flag = 0; exp_ill = 0; end
    else begin
      if (u) exp_flag = r;
      exp_ill = bd;
    end
    @(negedge clk);
    check(tag);
  endtask

  task automatic finish_run();
    if (finished) return;
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk);
    step(1, mk_reg(0, 0), 5, 5, "R1 reset");
    step(1, mk_reg(0, 0), 5, 5, "R1 reset");
    rst_n = 1'b1;
    // R2/R4: register equality then inequality
    step(1, mk_reg(0, 0), 32'h1234, 32'h1234, "R2 R4 eq true");
    step(1, mk_reg(1, 0), 32'h1234, 32'h1234, "R4 ne false");
    step(1, mk_reg(1, 0), 32'h1, 32'h2, "R4 ne true");
    // R5 vs R6: operands whose orders disagree
    step(1, mk_reg(2, 0), 32'h8000_0000, 32'h7fff_ffff, "R5 gtu");
    step(1, mk_reg(6, 0), 32'h8000_0000, 32'h7fff_ffff, "R6 gts");
    step(1, mk_reg(4, 0), 32'h8000_0000, 32'h7fff_ffff, "R5 ltu");
    step(1, mk_reg(8, 0), 32'h8000_0000, 32'h7fff_ffff, "R6 lts");
    // strict vs inclusive on equal operands
    step(1, mk_reg(3, 0), 32'hffff_ffff, 32'hffff_ffff, "R5 geu equal");
    step(1, mk_reg(4, 0), 32'hffff_ffff, 32'hffff_ffff, "R5 ltu equal");
    step(1, mk_reg(9, 0), 32'hffff_ffff, 32'hffff_ffff, "R6 les equal");
    step(1, mk_reg(5, 0), 32'h3, 32'h2, "R5 leu false");
    step(1, mk_reg(7, 0), 32'hffff_fffe, 32'hffff_ffff, "R6 ges false");
    // R3/R7: immediate extension
    step(1, mk_imm(0, 16'h8000), 32'hffff_8000, 0, "R3 R7 eq sext");
    step(1, mk_imm(2, 16'h8000), 32'hffff_8000, 0, "R7 gtu zext");
    step(1, mk_imm(8, 16'hffff), 32'hffff_fffe, 0, "R7 lts sext");
    step(1, mk_imm(4, 16'hffff), 32'h0001_0000, 0, "R7 ltu zext");
    step(1, mk_imm(1, 16'h0007), 32'h7, 0, "R3 ne imm");
    // R8: hold when idle or not a compare
    step(1, mk_reg(0, 0), 9, 9, "R8 set");
    step(0, mk_reg(1, 0), 9, 9, "R8 valid low");
    step(1, 32'h1400_0000, 9, 8, "R8 non-compare");
    step(1, {2'd2, 4'd13, 26'h0}, 9, 8, "R8 wrong subclass");
    // R9/R10: illegal forms
    step(1, mk_reg(10, 0), 1, 2, "R9 code 10");
    step(1, mk_imm(31, 16'h0), 1, 2, "R9 code 31 imm");
    step(0, 0, 0, 0, "R9 strobe drops");
    step(1, mk_reg(0, 11'h001), 3, 3, "R10 pad bit0");
    step(1, mk_reg(1, 11'h400), 3, 4, "R10 pad bit10");
    step(1, mk_reg(1, 0), 3, 4, "R10 clean after");
    // random mix
    for (int i = 0; i < 600; i++) begin
      int sel, code;
      logic [31:0] w, a, b;
      string tag;
      sel  = $urandom_range(0, 9);
      code = (sel == 9) ? $urandom_range(10, 31) : $urandom_range(0, 9);
      a = $urandom();
      b = ($urandom_range(0, 3) == 0) ? a : $urandom();
      if ($urandom_range(0, 1) == 0) a[31] = ~a[31];
      if (sel < 4) begin
        w = mk_reg(code, ($urandom_range(0, 7) == 0) ? 11'($urandom()) : 11'h0);
        tag = "R2 random reg";
      end else if (sel < 8) begin
        w = mk_imm(code, 16'($urandom()));
        if ($urandom_range(0, 2) == 0) a = {{16{w[15]}}, w[15:0]};
        tag = "R7 random imm";
      end else if (sel == 8) begin
        w = $urandom();
        tag = "R8 random word";
      end else begin
        w = mk_imm(code, 16'($urandom()));
        tag = "R9 random bad code";
      end
      step($urandom_range(0, 4) != 0, w, a, b, tag);
    end
    // R1: reset mid-run clears a set flag
    step(1, mk_reg(0, 0), 1, 1, "R1 pre");
    rst_n = 1'b0;
    step(1, mk_reg(10, 0), 1, 1, "R1 mid reset");
    rst_n = 1'b1;
    step(0, 0, 0, 0, "R1 after");
    finish_run();
  end

endmodule